// File: doc/BRIEF.md
# Addressed Serial Slave Front-End

This block is the serial slave port of a small multi-channel register device on a shared four-wire serial bus. It oversamples the bus pins on the system clock. It shifts in a frame MSB first on rising SCK edges. The frame is an identifier byte, then an instruction byte, then any data bytes. The block accepts the rest of the frame only when the identifier equals a fixed upper field joined to two strap pins, so up to four devices can share one bus. Decoded commands go to a register backend as single-cycle pulses. For read instructions, the backend's byte is shifted out on SO, changing after falling SCK edges. SO carries a separate output-enable for the pad.

A pause input lets the host freeze a transfer in mid-byte without losing state. Chip select going high aborts a frame at any point. After reset, no transaction is accepted until chip select has been seen falling. Requests to commit register contents to nonvolatile storage are refused while the write-protect pin is low, and each refusal is reported to the backend.

All bus pins are treated as synchronous to `clk`. Each SCK level must last at least two clock cycles.

Top module: `spi_slv_frontend`

## Requirements
- R1: SI is taken on each rising SCK edge, MSB first. The frame order is identifier byte, instruction byte, data bytes.
- R2: The identifier must equal {ID_HI, strap_addr_i[1:0]}. On a mismatch, no command and no block report is produced until CS_n next goes high.
- R3: The instruction class is given by instruction bits [7:6]. The classes are 00 control, 01 write, 10 read and 11 store. A control or store instruction ends the frame, and later bytes are ignored. A control instruction produces one command with cmd_has_data_o = 0.
- R4: In a write frame, each complete data byte produces one command pulse carrying the instruction, the data byte and cmd_has_data_o = 1.
- R5: A read instruction produces one command pulse with cmd_has_data_o = 0. rd_data_i is loaded at every eighth falling SCK edge after the instruction byte, starting with the first. It is shifted out MSB first on so_o, which changes only after a falling SCK edge.
- R6: so_oe_o is high only while a read frame has loaded data, CS_n is low and the bus is not paused. It is low during reset and within one clock after CS_n goes high.
- R7: After reset, a frame starts only on a high-to-low change of CS_n. If CS_n is already low when reset ends, no frame is started.
- R8: CS_n high at any point abandons the frame and any partial byte. The next frame starts again with the identifier byte.
- R9: HOLD_n is sampled only while SCK is low. HOLD_n low pauses the transfer: SCK edges are ignored and so_oe_o is low. HOLD_n high resumes the transfer with the partial byte intact.
- R10: A store instruction produces a command pulse when wp_n_i is high. When wp_n_i is low, it produces a wp_block_o pulse instead, with cmd_instr_o holding the instruction.
- R11: cmd_valid_o and wp_block_o are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Active-low pause |
| wp_n_i | input | 1 | Active-low write protect for store requests |
| strap_addr_i | input | 2 | Low two bits of the slave identifier |
| rd_data_i | input | 8 | Byte from the backend for read frames |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the SO pad |
| cmd_valid_o | output | 1 | Command pulse to the backend |
| cmd_instr_o | output | 8 | Instruction byte of the command or refused store |
| cmd_data_o | output | 8 | Data byte of the command |
| cmd_has_data_o | output | 1 | Command carries a data byte |
| wp_block_o | output | 1 | Store refused because write protect is low |

## Verification
The main function is driven with several frame types:
- A multi-byte write frame, where a dropped or doubled bit would show as misaligned data bytes.
- A control frame followed by a stray byte, which separates ending the frame from continuing to forward.
- A read frame of three bytes with the backend byte changed between bytes, which shows whether the reload happens at each byte boundary.
- A store frame sent under both write-protect levels.

Further frames cover the edge cases:
- Frames with a wrong identifier, and with the strap pins changed, show whether the comparison uses both the fixed field and the straps.
- A frame cut short by chip select, a frame started while chip select was already low at reset, and pauses in the middle of both a write byte and a read byte with junk SCK edges inside the pause, show that framing restarts where it should and holds where it should.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  localparam int BYTE_W = 8;

  // Instruction class field, top two bits of the instruction byte
  localparam logic [1:0] CLS_CTRL  = 2'b00;
  localparam logic [1:0] CLS_WRITE = 2'b01;
  localparam logic [1:0] CLS_READ  = 2'b10;
  localparam logic [1:0] CLS_STORE = 2'b11;

  typedef enum logic [2:0] {
    PH_ID,
    PH_INSTR,
    PH_DATA,
    PH_READ,
    PH_DROP
  } phase_e;

  typedef struct packed {
    logic              valid;
    logic              store;
    logic              has_data;
    logic [BYTE_W-1:0] instr;
    logic [BYTE_W-1:0] data;
  } spi_evt_t;

endpackage

// File: rtl/spi_slv_pin_qual.sv
module spi_slv_pin_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic hold_n_i,
  output logic rise_o,
  output logic fall_o,
  output logic clr_o,
  output logic paused_o,
  output logic in_frame_o
);

  logic sck_q, sck_d;
  logic cs_q, cs_d;
  logic paused_q, paused_d;
  logic in_frame_q, in_frame_d;
  logic live;

  always_comb begin
    sck_d      = sck_i;
    cs_d       = cs_n_i;
    paused_d   = paused_q;
    in_frame_d = in_frame_q;
    // pause input only takes effect while SCK is low
    if (!sck_i) paused_d = !hold_n_i;
    if (cs_n_i)                in_frame_d = 1'b0;
    else if (cs_q && !cs_n_i)  in_frame_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b0;   // low at reset: a select already low is not an edge
      paused_q   <= 1'b0;
      in_frame_q <= 1'b0;
    end else begin
      sck_q      <= sck_d;
      cs_q       <= cs_d;
      paused_q   <= paused_d;
      in_frame_q <= in_frame_d;
    end
  end

  assign live       = in_frame_q && !cs_n_i && !paused_q;
  assign rise_o     = live && sck_i && !sck_q;
  assign fall_o     = live && !sck_i && sck_q;
  assign clr_o      = cs_n_i;
  assign paused_o   = paused_q;
  assign in_frame_o = in_frame_q;

endmodule

// File: rtl/spi_slv_frame.sv
module spi_slv_frame
  import spi_slv_pkg::*;
#(
  parameter logic [BYTE_W-3:0] ID_HI = 6'b101000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_i,
  input  logic        clr_i,
  input  logic        si_i,
  input  logic [1:0]  strap_i,
  output spi_evt_t    evt_o,
  output logic        rd_phase_o
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [BYTE_W-1:0] instr_q, instr_d;
  spi_evt_t          evt_q, evt_d;
  logic [BYTE_W-1:0] byte_w;
  logic [BYTE_W-1:0] slave_id;

  assign byte_w   = {sh_q, si_i};
  assign slave_id = {ID_HI, strap_i};

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    instr_d = instr_q;
    evt_d   = '0;
    if (clr_i) begin
      phase_d = PH_ID;
      cnt_d   = '0;
    end else if (rise_i) begin
      sh_d  = byte_w[BYTE_W-2:0];
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        unique case (phase_q)
          PH_ID: phase_d = (byte_w == slave_id) ? PH_INSTR : PH_DROP;
          PH_INSTR: begin
            instr_d     = byte_w;
            evt_d.instr = byte_w;
            unique case (byte_w[BYTE_W-1 -: 2])
              CLS_WRITE: phase_d = PH_DATA;
              CLS_READ: begin
                phase_d     = PH_READ;
                evt_d.valid = 1'b1;
              end
              CLS_STORE: begin
                phase_d     = PH_DROP;
                evt_d.valid = 1'b1;
                evt_d.store = 1'b1;
              end
              default: begin
                phase_d     = PH_DROP;
                evt_d.valid = 1'b1;
              end
            endcase
          end
          PH_DATA: begin
            evt_d.valid    = 1'b1;
            evt_d.has_data = 1'b1;
            evt_d.instr    = instr_q;
            evt_d.data     = byte_w;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ID;
      cnt_q   <= '0;
      sh_q    <= '0;
      instr_q <= '0;
      evt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      instr_q <= instr_d;
      evt_q   <= evt_d;
    end
  end

  assign evt_o      = evt_q;
  assign rd_phase_o = (phase_q == PH_READ);

endmodule

// File: rtl/spi_slv_tx.sv
module spi_slv_tx
  import spi_slv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              rd_phase_i,
  input  logic              clr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              so_o,
  output logic              live_o
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              live_q, live_d;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    live_d = live_q;
    if (clr_i) begin
      cnt_d  = '0;
      live_d = 1'b0;
    end else if (fall_i && rd_phase_i) begin
      // byte boundary reloads from the backend, otherwise shift toward MSB
      sr_d   = (cnt_q == '0) ? rd_data_i : {sr_q[BYTE_W-2:0], 1'b0};
      cnt_d  = cnt_q + 1'b1;
      live_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      live_q <= live_d;
    end
  end

  assign so_o   = sr_q[BYTE_W-1];
  assign live_o = live_q;

endmodule

// File: rtl/spi_slv_wp_gate.sv
module spi_slv_wp_gate
  import spi_slv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  spi_evt_t          evt_i,
  input  logic              wp_n_i,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_instr_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  output logic              cmd_has_data_o,
  output logic              wp_block_o
);

  logic              vld_q, vld_d;
  logic              blk_q, blk_d;
  logic              hd_q, hd_d;
  logic [BYTE_W-1:0] ins_q, ins_d;
  logic [BYTE_W-1:0] dat_q, dat_d;

  always_comb begin
    vld_d = evt_i.valid && (!evt_i.store || wp_n_i);
    blk_d = evt_i.valid && evt_i.store && !wp_n_i;
    hd_d  = hd_q;
    ins_d = ins_q;
    dat_d = dat_q;
    if (evt_i.valid) begin
      hd_d  = evt_i.has_data;
      ins_d = evt_i.instr;
      dat_d = evt_i.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      blk_q <= 1'b0;
      hd_q  <= 1'b0;
      ins_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      blk_q <= blk_d;
      hd_q  <= hd_d;
      ins_q <= ins_d;
      dat_q <= dat_d;
    end
  end

  assign cmd_valid_o    = vld_q;
  assign wp_block_o     = blk_q;
  assign cmd_has_data_o = hd_q;
  assign cmd_instr_o    = ins_q;
  assign cmd_data_o     = dat_q;

endmodule

// File: rtl/spi_slv_frontend.sv
module spi_slv_frontend
  import spi_slv_pkg::*;
#(
  parameter logic [BYTE_W-3:0] ID_HI = 6'b101000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  input  logic              hold_n_i,
  input  logic              wp_n_i,
  input  logic [1:0]        strap_addr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_instr_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  output logic              cmd_has_data_o,
  output logic              wp_block_o
);

  logic     rise, fall, clr, paused, in_frame;
  logic     rd_phase, tx_live;
  spi_evt_t evt;

  spi_slv_pin_qual u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_i      (sck_i),
    .cs_n_i     (cs_n_i),
    .hold_n_i   (hold_n_i),
    .rise_o     (rise),
    .fall_o     (fall),
    .clr_o      (clr),
    .paused_o   (paused),
    .in_frame_o (in_frame)
  );

  spi_slv_frame #(.ID_HI(ID_HI)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise),
    .clr_i      (clr),
    .si_i       (si_i),
    .strap_i    (strap_addr_i),
    .evt_o      (evt),
    .rd_phase_o (rd_phase)
  );

  spi_slv_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_i     (fall),
    .rd_phase_i (rd_phase),
    .clr_i      (clr),
    .rd_data_i  (rd_data_i),
    .so_o       (so_o),
    .live_o     (tx_live)
  );

  spi_slv_wp_gate u_gate (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_i          (evt),
    .wp_n_i         (wp_n_i),
    .cmd_valid_o    (cmd_valid_o),
    .cmd_instr_o    (cmd_instr_o),
    .cmd_data_o     (cmd_data_o),
    .cmd_has_data_o (cmd_has_data_o),
    .wp_block_o     (wp_block_o)
  );

  assign so_oe_o = tx_live && in_frame && !paused;

endmodule

// File: rtl/spi_slv_frontend_chk.sv
module spi_slv_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck_i,
  input logic       cs_n_i,
  input logic       hold_n_i,
  input logic       wp_n_i,
  input logic       so_o,
  input logic       so_oe_o,
  input logic       cmd_valid_o,
  input logic [1:0] cls_i,
  input logic       wp_block_o
);

  // observer of chip-select history at the pins
  logic ck_cs_q, ck_armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_cs_q  <= 1'b0;
      ck_armed <= 1'b0;
    end else begin
      ck_cs_q <= cs_n_i;
      if (ck_cs_q && !cs_n_i) ck_armed <= 1'b1;
    end
  end

  p_cmd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  p_blk_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wp_block_o |=> !wp_block_o);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && wp_block_o));
  p_oe_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> !so_oe_o);
  p_oe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n_i && !sck_i) |=> !so_oe_o);
  p_blk_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wp_block_o |-> (cls_i == 2'b11));
  p_store_wp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cls_i == 2'b11) |-> $past(wp_n_i));
  p_so_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (so_o != $past(so_o)) |-> (!$past(sck_i) && $past(sck_i, 2)));
  p_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o || wp_block_o) |-> ck_armed);

endmodule

bind spi_slv_frontend spi_slv_frontend_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sck_i       (sck_i),
  .cs_n_i      (cs_n_i),
  .hold_n_i    (hold_n_i),
  .wp_n_i      (wp_n_i),
  .so_o        (so_o),
  .so_oe_o     (so_oe_o),
  .cmd_valid_o (cmd_valid_o),
  .cls_i       (cmd_instr_o[7:6]),
  .wp_block_o  (wp_block_o)
);

// File: tb/spi_slv_frontend_tb_top.sv
module spi_slv_frontend_tb_top;

  localparam logic [5:0] ID_HI = 6'b101000;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sck, cs_n, si, hold_n, wp_n;
  logic [1:0] strap;
  logic [7:0] rd_data;
  logic       so_o, so_oe_o, cmd_valid_o, cmd_has_data_o, wp_block_o;
  logic [7:0] cmd_instr_o, cmd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    bit         blk;
    logic [7:0] instr;
    logic [7:0] data;
    bit         hd;
    string      req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  spi_slv_frontend #(.ID_HI(ID_HI)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
    .hold_n_i(hold_n), .wp_n_i(wp_n), .strap_addr_i(strap), .rd_data_i(rd_data),
    .so_o(so_o), .so_oe_o(so_oe_o), .cmd_valid_o(cmd_valid_o),
    .cmd_instr_o(cmd_instr_o), .cmd_data_o(cmd_data_o),
    .cmd_has_data_o(cmd_has_data_o), .wp_block_o(wp_block_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit blk, input logic [7:0] ins, input logic [7:0] dat,
                      input bit hd, input string req);
    exp_t e;
    e.blk = blk; e.instr = ins; e.data = dat; e.hd = hd; e.req = req;
    q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (cmd_valid_o || wp_block_o)) begin
      if (q.size() == 0) begin
        chk(0, "R2/R3/R7", "unexpected output pulse", {cmd_instr_o, cmd_data_o}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(wp_block_o == e.blk && cmd_valid_o == !e.blk, e.req, "pulse kind",
            {cmd_valid_o, wp_block_o}, {!e.blk, e.blk});
        chk(cmd_instr_o == e.instr, e.req, "instr", cmd_instr_o, e.instr);
        if (!e.blk) begin
          chk(cmd_has_data_o == e.hd, e.req, "has_data", cmd_has_data_o, e.hd);
          if (e.hd) chk(cmd_data_o == e.data, e.req, "data", cmd_data_o, e.data);
        end
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    si = b;
    wclk(HALF);
    r = so_o;
    sck = 1'b1;
    wclk(HALF);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
  endtask

  task automatic sbyte(input logic [7:0] tx);
    logic [7:0] d;
    xbyte(tx, d);
  endtask

  task automatic cs_lo;
    cs_n = 1'b0; wclk(HALF);
  endtask

  task automatic cs_hi;
    wclk(HALF); cs_n = 1'b1; wclk(6);
  endtask

  task automatic junk_edges(input int n);
    for (int i = 0; i < n; i++) begin
      si = i[0];
      wclk(HALF); sck = 1'b1; wclk(HALF); sck = 1'b0;
    end
  endtask

  initial begin
    logic [7:0] rx;
    logic       b;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b0; si = 1'b0; hold_n = 1'b1; wp_n = 1'b1;
    strap = 2'b01; rd_data = 8'h00;
    wclk(5);
    rst_n = 1'b1;
    wclk(2);
    chk(so_oe_o == 0, "R6", "reset so_oe", so_oe_o, 0);
    chk(cmd_valid_o == 0 && wp_block_o == 0, "R11", "reset pulses",
        {cmd_valid_o, wp_block_o}, 0);

    // R7: select already low at reset, full frame must be ignored
    sbyte({ID_HI, 2'b01}); sbyte(8'h41); sbyte(8'h77);
    cs_hi();

    // R1 R4: write frame, two data bytes
    cs_lo();
    sbyte({ID_HI, 2'b01}); sbyte(8'h4A);
    push(0, 8'h4A, 8'h3C, 1, "R4"); sbyte(8'h3C);
    push(0, 8'h4A, 8'hC5, 1, "R1"); sbyte(8'hC5);
    chk(so_oe_o == 0, "R6", "so_oe in write", so_oe_o, 0);
    cs_hi();

    // R2: wrong identifier
    cs_lo();
    sbyte({ID_HI, 2'b10}); sbyte(8'h41); sbyte(8'h12);
    cs_hi();
    cs_lo();
    sbyte({6'b101001, 2'b01}); sbyte(8'h41); sbyte(8'h13);
    cs_hi();
    // R2: new strap value accepted
    strap = 2'b10;
    cs_lo();
    sbyte({ID_HI, 2'b10}); sbyte(8'h55);
    push(0, 8'h55, 8'hE1, 1, "R2"); sbyte(8'hE1);
    cs_hi();
    strap = 2'b01;

    // R3: control instruction ends the frame
    cs_lo();
    sbyte({ID_HI, 2'b01});
    push(0, 8'h15, 8'h00, 0, "R3"); sbyte(8'h15);
    sbyte(8'hFF);
    cs_hi();

    // R5 R6 R9: read frame with reload and a pause
    rd_data = 8'hA6;
    cs_lo();
    sbyte({ID_HI, 2'b01});
    push(0, 8'h85, 8'h00, 0, "R5"); sbyte(8'h85);
    xbyte(8'h00, rx);
    rd_data = 8'h5B;
    chk(rx == 8'hA6, "R5", "read byte 1", rx, 8'hA6);
    chk(so_oe_o == 1, "R6", "so_oe in read", so_oe_o, 1);
    xbyte(8'h00, rx);
    rd_data = 8'h3E;
    chk(rx == 8'h5B, "R5", "read byte 2 reload", rx, 8'h5B);
    for (int i = 7; i >= 5; i--) begin xbit(1'b0, b); rx[i] = b; end
    hold_n = 1'b0; wclk(3);
    chk(so_oe_o == 0, "R9", "so_oe in pause", so_oe_o, 0);
    junk_edges(3);
    hold_n = 1'b1; wclk(3);
    chk(so_oe_o == 1, "R9", "so_oe after resume", so_oe_o, 1);
    for (int i = 4; i >= 0; i--) begin xbit(1'b0, b); rx[i] = b; end
    chk(rx == 8'h3E, "R9", "read byte across pause", rx, 8'h3E);
    wclk(HALF); cs_n = 1'b1; wclk(2);
    chk(so_oe_o == 0, "R6", "so_oe after deselect", so_oe_o, 0);
    wclk(4);

    // R9: pause inside a write data byte
    cs_lo();
    sbyte({ID_HI, 2'b01}); sbyte(8'h62);
    xbit(1'b1, b); xbit(1'b0, b); xbit(1'b0, b);
    hold_n = 1'b0; wclk(3);
    junk_edges(2);
    hold_n = 1'b1; wclk(3);
    push(0, 8'h62, 8'h96, 1, "R9");
    xbit(1'b1, b); xbit(1'b0, b); xbit(1'b1, b); xbit(1'b1, b); xbit(1'b0, b);
    cs_hi();

    // R10: store gated by write protect
    wp_n = 1'b0;
    cs_lo();
    sbyte({ID_HI, 2'b01});
    push(1, 8'hC3, 8'h00, 0, "R10"); sbyte(8'hC3);
    sbyte(8'h41);
    cs_hi();
    wp_n = 1'b1;
    cs_lo();
    sbyte({ID_HI, 2'b01});
    push(0, 8'hC3, 8'h00, 0, "R10"); sbyte(8'hC3);
    cs_hi();

    // R8: abort mid-instruction, then a clean frame
    cs_lo();
    sbyte({ID_HI, 2'b01});
    xbit(1'b0, b); xbit(1'b1, b); xbit(1'b1, b);
    cs_hi();
    cs_lo();
    sbyte({ID_HI, 2'b01}); sbyte(8'h40);
    push(0, 8'h40, 8'h99, 1, "R8"); sbyte(8'h99);
    cs_hi();

    wclk(20);
    chk(q.size() == 0, "R11", "missing pulses", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule